// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Responder

This block models the target side of a two-wire serial EEPROM. The memory holds 256 bytes and can only be read from the bus. A host that bit-bangs the bus presents the current clock and data line levels on `sclIn` and `sdaIn`. It pulses `updStrobe` for one cycle each time it changes either line. The responder acts only on those update events and never samples on its own.

On each event the block does one of four things. It detects start and stop conditions, it ignores traffic while it is idle, it samples a bit on a clock rising edge, or it inserts an acknowledge. A transaction is a command byte followed by a word-address byte. A single tick counter sequences it, with a fixed threshold after each byte. When the address byte is complete, the byte at that address is loaded into an output shift register. If the command of a later transaction marks a read, its address phase shifts that byte out, MSB first. The memory image comes from a parameter.

Top module: `i2c_eeprom_responder`

## Requirements
- R1: After reset, asserted at any time, `sdaOut` is 1 and the block is idle. Clock edges then have no effect until a start condition, so no acknowledge appears.
- R2: Without `updStrobe`, changes on `sclIn`/`sdaIn` leave `sdaOut` and all internal state unchanged.
- R3: With SCL high before and after an update, a 1-to-0 change of SDA is a start condition. It sets the tick counter to 1 and clears the command byte. A 0-to-1 change is a stop condition, which leaves the counter and the transaction in progress untouched.
- R4: While the tick counter is 0 and no acknowledge is pending, every update except a start condition is ignored.
- R5: A bit is taken only on an update where SCL goes 0 to 1 and SDA equals its stored value. If SDA changed on that update, the bit is dropped and the counter does not advance.
- R6: The first 8 bits after a start are shifted MSB first into the command byte. After the 8th bit, an acknowledge is pending. The next rising SCL update then forces `sdaOut` to 0, whatever the host drives, and clears the pending flag.
- R7: The next 8 bits are shifted MSB first into the word address. On each of them the data shift register moves left by one. If bit 0 of the command is 1 (read), that rising update drives `sdaOut` with the data register MSB as it stood before the shift. If bit 0 is 0, `sdaOut` follows the host.
- R8: On the 8th address bit, the data register is loaded from the memory at the completed address and an acknowledge becomes pending. The counter returns to 0, so the block is idle once that acknowledge has been given.
- R9: Memory byte i is bits [8i+7:8i] of parameter `MEM_INIT`.
- R10: After every update, `sdaOut` equals the SDA level the block stored: the host's `sdaIn` unless an acknowledge or a read bit overrode it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| updStrobe | input | 1 | One-cycle pulse: the line levels have changed |
| sclIn | input | 1 | Clock line level driven by the host |
| sdaIn | input | 1 | Data line level driven by the host |
| sdaOut | output | 1 | Data line level the responder holds |

## Verification
The tick counter and the pending-acknowledge flag never reach the ports directly. Their errors show up as a forced-low bit in the wrong clock position, so a counter that is off by one moves the acknowledge one bit earlier or later. That shift is visible on the very next rising update after the 8th or 16th bit. A data register loaded from the wrong address, or shifted at the wrong time, goes unseen until the next transaction with the read bit set. There, every bit of its address phase exposes it. A responder that wrongly leaves the idle state keeps the data line low at a position where it should echo the host.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

  localparam int unsigned ROM_DATA_W = 8;
  localparam int unsigned ROM_ADDR_W = 8;
  localparam int unsigned ROM_DEPTH  = 1 << ROM_ADDR_W;

  typedef logic [ROM_DEPTH*ROM_DATA_W-1:0] romImage_t;

  // Strobes from the sequencing control to the datapath.
  typedef struct packed {
    logic store;      // latch the line levels
    logic clrCmd;     // start seen: clear command byte
    logic shiftCmd;   // take a command bit
    logic shiftAddr;  // take an address bit, shift data left
    logic loadData;   // fetch the byte at the completed address
    logic driveAck;   // force the stored data line low
    logic driveData;  // put the data register MSB on the line
  } ctrlStrobe_t;

  function automatic romImage_t defaultImage();
    romImage_t img;
    for (int i = 0; i < ROM_DEPTH; i++) begin
      img[i*ROM_DATA_W +: ROM_DATA_W] = ROM_DATA_W'((i * 37 + 90) ^ (i >> 3));
    end
    return img;
  endfunction

endpackage

// File: rtl/i2c_eeprom_ctrl.sv
module i2c_eeprom_ctrl
  import i2c_eeprom_pkg::*;
#(
  parameter int unsigned CMD_W  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned TICK_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              updStrobe,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              sclQ,
  input  logic              sdaQ,
  input  logic              cmdRead,
  output ctrlStrobe_t       strobe,
  output logic [TICK_W-1:0] tickQ,
  output logic              ackPend
);

  localparam int unsigned CMD_END  = CMD_W + 1;
  localparam int unsigned ADDR_END = CMD_END + ADDR_W;
  localparam logic [TICK_W-1:0] CMD_END_T  = TICK_W'(CMD_END);
  localparam logic [TICK_W-1:0] CMD_LAST_T = TICK_W'(CMD_END - 1);
  localparam logic [TICK_W-1:0] ADDR_END_T = TICK_W'(ADDR_END);
  localparam logic [TICK_W-1:0] ADDR_LAST_T = TICK_W'(ADDR_END - 1);

  logic [TICK_W-1:0] tickNext;
  logic              ackNext;
  logic              busCond;
  logic              sclRise;
  logic              idleHold;

  assign busCond  = sclQ && sclIn && (sdaQ != sdaIn);
  assign sclRise  = !sclQ && sclIn;
  assign idleHold = (tickQ == '0) && !ackPend;

  always_comb begin
    strobe       = '0;
    strobe.store = updStrobe;
    tickNext     = tickQ;
    ackNext      = ackPend;
    if (updStrobe) begin
      if (busCond) begin
        if (!sdaIn) begin
          tickNext      = TICK_W'(1);
          strobe.clrCmd = 1'b1;
        end
      end else if (!idleHold && sclRise) begin
        if (ackPend) begin
          strobe.driveAck = 1'b1;
          ackNext         = 1'b0;
        end else if (sdaQ == sdaIn) begin
          if (tickQ < CMD_END_T) begin
            strobe.shiftCmd = 1'b1;
            tickNext        = tickQ + 1'b1;
            if (tickQ == CMD_LAST_T) ackNext = 1'b1;
          end else if (tickQ < ADDR_END_T) begin
            strobe.shiftAddr = 1'b1;
            strobe.driveData = cmdRead;
            if (tickQ == ADDR_LAST_T) begin
              strobe.loadData = 1'b1;
              ackNext         = 1'b1;
              tickNext        = '0;
            end else begin
              tickNext = tickQ + 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickQ   <= '0;
      ackPend <= 1'b0;
    end else begin
      tickQ   <= tickNext;
      ackPend <= ackNext;
    end
  end

endmodule

// File: rtl/i2c_eeprom_datapath.sv
module i2c_eeprom_datapath
  import i2c_eeprom_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 8,
  parameter logic [(2**ADDR_W)*DATA_W-1:0] MEM_INIT = '0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  ctrlStrobe_t strobe,
  output logic        sclQ,
  output logic        sdaQ,
  output logic        cmdRead
);

  localparam int unsigned DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] cmdReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [ADDR_W-1:0] addrNext;
  logic [DATA_W-1:0] romByte;
  logic              sdaNext;
  logic [DATA_W-1:0] romArr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gRom
    assign romArr[g] = MEM_INIT[g*DATA_W +: DATA_W];
  end

  assign addrNext = {addrReg[ADDR_W-2:0], sdaIn};
  assign romByte  = romArr[addrNext];
  assign cmdRead  = cmdReg[0];

  always_comb begin
    if (strobe.driveAck)       sdaNext = 1'b0;
    else if (strobe.driveData) sdaNext = dataReg[DATA_W-1];
    else                       sdaNext = sdaIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
      cmdReg  <= '0;
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (strobe.store) begin
        sclQ <= sclIn;
        sdaQ <= sdaNext;
      end
      if (strobe.clrCmd)        cmdReg <= '0;
      else if (strobe.shiftCmd) cmdReg <= {cmdReg[DATA_W-2:0], sdaIn};
      if (strobe.shiftAddr)     addrReg <= addrNext;
      if (strobe.loadData)       dataReg <= romByte;
      else if (strobe.shiftAddr) dataReg <= {dataReg[DATA_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/i2c_eeprom_responder.sv
module i2c_eeprom_responder
  import i2c_eeprom_pkg::*;
#(
  parameter int unsigned DATA_W = ROM_DATA_W,
  parameter int unsigned ADDR_W = ROM_ADDR_W,
  parameter logic [(2**ADDR_W)*DATA_W-1:0] MEM_INIT = defaultImage()
) (
  input  logic clk,
  input  logic rstN,
  input  logic updStrobe,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOut
);

  localparam int unsigned TICK_LAST = DATA_W + ADDR_W;
  localparam int unsigned TICK_W    = $clog2(TICK_LAST + 2);

  ctrlStrobe_t       strobe;
  logic              sclLine;
  logic              sdaLine;
  logic              cmdRead;
  logic [TICK_W-1:0] tickCnt;
  logic              ackPend;

  i2c_eeprom_ctrl #(
    .CMD_W (DATA_W),
    .ADDR_W(ADDR_W),
    .TICK_W(TICK_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .updStrobe(updStrobe),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .sclQ     (sclLine),
    .sdaQ     (sdaLine),
    .cmdRead  (cmdRead),
    .strobe   (strobe),
    .tickQ    (tickCnt),
    .ackPend  (ackPend)
  );

  i2c_eeprom_datapath #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .MEM_INIT(MEM_INIT)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .strobe (strobe),
    .sclQ   (sclLine),
    .sdaQ   (sdaLine),
    .cmdRead(cmdRead)
  );

  assign sdaOut = sdaLine;

endmodule

// File: rtl/i2c_eeprom_checker.sv
module i2c_eeprom_checker #(
  parameter int unsigned TICK_W    = 5,
  parameter int unsigned TICK_LAST = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              updStrobe,
  input logic              sclIn,
  input logic              sdaIn,
  input logic              sdaOut,
  input logic              sclQ,
  input logic [TICK_W-1:0] tickQ,
  input logic              ackPend
);

  localparam logic [TICK_W-1:0] TMAX = TICK_W'(TICK_LAST);

  logic startEv;
  logic riseEv;
  assign startEv = updStrobe && sclQ && sclIn && sdaOut && !sdaIn;
  assign riseEv  = updStrobe && !sclQ && sclIn;

  assert_no_strobe_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !updStrobe |=> ($stable(sdaOut) && $stable(tickQ) && $stable(ackPend)));

  assert_start_sets_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> (tickQ == TICK_W'(1)));

  assert_idle_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (updStrobe && tickQ == '0 && !ackPend && !startEv) |=> (tickQ == '0 && !ackPend));

  assert_changed_bit_dropped_R5: assert property (@(posedge clk) disable iff (!rstN)
    (riseEv && !ackPend && sdaOut != sdaIn) |=> $stable(tickQ));

  assert_ack_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (riseEv && ackPend) |=> (!sdaOut && !ackPend));

  assert_tick_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    tickQ <= TMAX);

  assert_low_scl_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    (updStrobe && !sclIn) |=> (sdaOut == $past(sdaIn)));

endmodule

bind i2c_eeprom_responder i2c_eeprom_checker #(
  .TICK_W   (TICK_W),
  .TICK_LAST(TICK_LAST)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .updStrobe(updStrobe),
  .sclIn    (sclIn),
  .sdaIn    (sdaIn),
  .sdaOut   (sdaOut),
  .sclQ     (sclLine),
  .tickQ    (tickCnt),
  .ackPend  (ackPend)
);

// File: tb/i2c_eeprom_responder_test.sv
module i2c_eeprom_responder_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic updStrobe = 1'b0;
  logic sclIn = 1'b1;
  logic sdaIn = 1'b1;
  logic sdaOut;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  function automatic i2c_eeprom_pkg::romImage_t benchImage();
    i2c_eeprom_pkg::romImage_t img;
    for (int i = 0; i < 256; i++) img[i*8 +: 8] = 8'(i * 13 + 7) ^ 8'(i >> 2);
    return img;
  endfunction

  localparam i2c_eeprom_pkg::romImage_t IMG = benchImage();
  localparam logic [7:0] VEC_ADDR [5] = '{8'h00, 8'h3C, 8'h7F, 8'hA5, 8'hFF};
  localparam logic [7:0] VEC_RDADDR [5] = '{8'h5A, 8'h01, 8'hC3, 8'h80, 8'h2E};

  i2c_eeprom_responder #(.MEM_INIT(IMG)) uut (
    .clk(clk), .rstN(rstN), .updStrobe(updStrobe),
    .sclIn(sclIn), .sdaIn(sdaIn), .sdaOut(sdaOut)
  );

  function automatic logic [7:0] byteAt(input logic [7:0] a);
    return IMG[int'(a)*8 +: 8];
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic s, input logic d);
    @(negedge clk);
    sclIn = s; sdaIn = d; updStrobe = 1'b1;
    @(negedge clk);
    updStrobe = 1'b0;
  endtask

  task automatic clkBit(input logic b, output logic o);
    pulse(1'b0, b);
    pulse(1'b1, b);
    o = sdaOut;
    pulse(1'b0, b);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic [7:0] o);
    for (int i = 7; i >= 0; i--) begin
      logic x;
      clkBit(v[i], x);
      o[i] = x;
    end
  endtask

  task automatic startCond();
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b1);
    pulse(1'b1, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] o;
    logic x;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(sdaOut == 1'b1, "R1 reset level", {7'd0, sdaOut}, 8'h01);

    // R2: line changes without a strobe do nothing
    sclIn = 1'b1; sdaIn = 1'b0;
    repeat (4) @(negedge clk);
    check(sdaOut == 1'b1, "R2 no strobe", {7'd0, sdaOut}, 8'h01);
    sdaIn = 1'b1;
    @(negedge clk);

    // R4: idle traffic echoes and never acknowledges
    sendByte(8'hA0, o);
    check(o == 8'hA0, "R4 idle echo", o, 8'hA0);
    clkBit(1'b1, x);
    check(x == 1'b1, "R4 no ack while idle", {7'd0, x}, 8'h01);

    // Table walk: set address, then read it back
    for (int v = 0; v < 5; v++) begin
      startCond();
      sendByte(8'hA0, o);
      check(o == 8'hA0, "R10 command echo", o, 8'hA0);
      clkBit(1'b1, x);
      check(x == 1'b0, "R6 command ack", {7'd0, x}, 8'h00);
      sendByte(VEC_ADDR[v], o);
      check(o == VEC_ADDR[v], "R7 write-mode address echo", o, VEC_ADDR[v]);
      clkBit(1'b1, x);
      check(x == 1'b0, "R8 address ack", {7'd0, x}, 8'h00);
      startCond();
      sendByte(8'hA1, o);
      clkBit(1'b1, x);
      check(x == 1'b0, "R6 read command ack", {7'd0, x}, 8'h00);
      sendByte(VEC_RDADDR[v], o);
      check(o == byteAt(VEC_ADDR[v]), "R9 read data", o, byteAt(VEC_ADDR[v]));
      clkBit(1'b1, x);
      check(x == 1'b0, "R8 read ack", {7'd0, x}, 8'h00);
    end

    // R8: idle after the final ack; the read phase itself loaded the next byte
    clkBit(1'b1, x);
    check(x == 1'b1, "R8 idle after ack", {7'd0, x}, 8'h01);
    startCond();
    sendByte(8'hA1, o);
    clkBit(1'b1, x);
    sendByte(8'h00, o);
    check(o == byteAt(8'h2E), "R8 chained load", o, byteAt(8'h2E));
    clkBit(1'b1, x);

    // R3: stop mid-command leaves counting intact
    startCond();
    clkBit(1'b1, x);
    clkBit(1'b0, x);
    pulse(1'b0, 1'b0);
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b1);
    pulse(1'b0, 1'b1);
    for (int i = 0; i < 5; i++) clkBit(1'b0, x);
    clkBit(1'b1, x);
    check(x == 1'b0, "R3 stop keeps count", {7'd0, x}, 8'h00);
    sendByte(8'h10, o);
    clkBit(1'b1, x);

    // R3: restart mid-command resets the counter
    startCond();
    clkBit(1'b1, x);
    clkBit(1'b1, x);
    clkBit(1'b0, x);
    startCond();
    for (int i = 7; i >= 1; i--) clkBit(8'hA1 >> i, x);
    check(x == 1'b0, "R3 bit before ack is host", {7'd0, x}, 8'h00);
    clkBit(1'b1, x);
    check(x == 1'b1, "R3 restart no early ack", {7'd0, x}, 8'h01);
    clkBit(1'b1, x);
    check(x == 1'b0, "R3 ack after restart", {7'd0, x}, 8'h00);
    sendByte(8'h20, o);
    check(o == byteAt(8'h10), "R7 read after restart", o, byteAt(8'h10));
    clkBit(1'b1, x);

    // R5: bit with SDA changing on the rising update is dropped
    startCond();
    clkBit(1'b1, x); clkBit(1'b0, x); clkBit(1'b1, x); clkBit(1'b0, x);
    clkBit(1'b0, x); clkBit(1'b0, x); clkBit(1'b0, x);
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b0);
    clkBit(1'b0, x);
    clkBit(1'b1, x);
    check(x == 1'b0, "R5 dropped bit", {7'd0, x}, 8'h00);
    sendByte(8'h33, o);
    clkBit(1'b1, x);

    // R1: reset during a command returns to idle
    startCond();
    clkBit(1'b1, x); clkBit(1'b0, x); clkBit(1'b1, x);
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(sdaOut == 1'b1, "R1 mid-run reset level", {7'd0, sdaOut}, 8'h01);
    for (int i = 0; i < 8; i++) clkBit(1'b1, x);
    clkBit(1'b1, x);
    check(x == 1'b1, "R1 idle after reset", {7'd0, x}, 8'h01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule